// File: doc/BRIEF.md
# Page-Indexed Address Translation Table

This block rewrites a 64-bit address by looking up a small table that is indexed directly by address bits, with no tag compare. A fixed group of address bits just above the page offset picks one entry. That entry holds a valid flag, a base page number in 4 KB units and a 16-bit attribute. The page-aligned part of the base is joined with the in-page offset of the incoming address to form the result. The attribute, which carries routing hints such as the packet kind, is passed along with the result.

The page size (`PAGE_SHIFT`) and the entry count (`NUM_ENTRIES`) are parameters. Typical settings are 64 entries of 16 KB or 16 entries of 64 KB. Software programs the entries through a 32-bit register write port that maps onto a 4 KB window, with 16 bytes per entry. Lookups return their result one cycle later, with an error flag for invalid entries and for indices past the end of the table. When `OUTBOUND` is set, the result is limited to a 52-bit address.

Top module: `page_xlat_table`

## Requirements
- R1: The entry index is `lk_addr[PAGE_SHIFT +: IW]`, where IW = ceil(log2(NUM_ENTRIES)). This equals `(addr >> PAGE_SHIFT) & 0x3F` for 64 entries and `& 0xF` for 12 or 16 entries. Address bits above the index do not take part in entry selection.
- R2: A lookup returns `res_err`=1 if the selected entry's valid bit is clear or if the index is NUM_ENTRIES or more.
- R3: On a hit, `res_addr` = (({base, 12'b0}) AND NOT pm) OR (lk_addr AND pm), where pm = 2^PAGE_SHIFT − 1 and base is the 52-bit page number of the entry.
- R4: On a hit, `res_attr` equals the 16-bit attribute stored in the selected entry.
- R5: A write with `cfg_we`=1 selects the entry slot with `cfg_addr[11:4]` and the word with `cfg_addr[3:2]`. Word 0 bit 0 is the valid bit. Word 1 is base[31:0]. Word 2 bits [19:0] are base[51:32]. Word 3 bits [15:0] are the attribute. Each write changes only the field it addresses.
- R6: `res_valid` is 1 in the cycle after a cycle with `lk_valid`=1, and 0 after a cycle with `lk_valid`=0.
- R7: If a lookup and a write to the same entry happen in the same cycle, the lookup returns the entry's contents from before the write.
- R8: Reset clears every valid bit, so every lookup after reset reports an error until an entry is validated. `res_valid` is 0 during reset.
- R9: With `OUTBOUND`=1, `res_addr[63:52]` is always 0.
- R10: When `res_err`=1, `res_addr` and `res_attr` are both 0.
- R11: A write whose slot `cfg_addr[11:4]` is NUM_ENTRIES or more changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Byte offset in the 4 KB configuration window |
| cfg_wdata | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Address to translate |
| res_valid | output | 1 | Result present (one cycle after request) |
| res_err | output | 1 | Decode error: invalid entry or index out of range |
| res_addr | output | 64 | Translated address |
| res_attr | output | 16 | Attribute of the selected entry |

## Verification
The bench drives two instances side by side. One has 64 entries of 16 KB pages. The other has 12 entries of 64 KB pages with the 52-bit limit, so its 4-bit index can point past the end of the table. If a design skipped the range check, that second instance would return data from a non-existent entry instead of an error. Base values with every low bit set would expose a design that forgets to mask the base to the page size, because the offset would get ORed into the wrong bits. High address bits above the index would expose a design that lets them leak into the entry selection. The bench also hits a write and a lookup to the same entry in the same cycle; a bypassing design would return the new contents instead of the old ones. It writes to slots past the end of the table; a design that wraps the slot number would corrupt a low entry.

// File: rtl/page_xlat_pkg.sv
package page_xlat_pkg;

  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned CFG_AW     = 12;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned ATTR_W     = 16;
  localparam int unsigned GRAN_SHIFT = 12;
  localparam int unsigned BASE_W     = ADDR_W - GRAN_SHIFT;
  localparam int unsigned BASE_HI_W  = BASE_W - WORD_W;
  localparam int unsigned LIMIT_W    = 52;
  localparam int unsigned SLOT_LSB   = 4;
  localparam int unsigned SLOT_W     = CFG_AW - SLOT_LSB;

  typedef enum logic [1:0] {
    WD_CTRL    = 2'd0,
    WD_BASE_LO = 2'd1,
    WD_BASE_HI = 2'd2,
    WD_ATTR    = 2'd3
  } word_sel_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [ATTR_W-1:0] attr;
  } entry_data_t;

endpackage

// File: rtl/page_xlat_rst_sync.sv
module page_xlat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_q_n = stage_q[1];

endmodule

// File: rtl/page_xlat_store.sv
module page_xlat_store
  import page_xlat_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [WORD_W-1:0]             cfg_wdata,
  output logic [NUM_ENTRIES-1:0]        valid_o,
  output entry_data_t [NUM_ENTRIES-1:0] data_o
);

  logic [SLOT_W-1:0] slot;
  word_sel_e         wsel;
  logic              unused_low;

  assign slot       = cfg_addr[CFG_AW-1:SLOT_LSB];
  assign wsel       = word_sel_e'(cfg_addr[3:2]);
  assign unused_low = ^cfg_addr[1:0];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic                 sel;
    logic                 ctrl_en, lo_en, hi_en, attr_en;
    logic                 valid_q;
    logic [BASE_W-1:0]    base_q;
    logic [ATTR_W-1:0]    attr_q;

    // Slots at or beyond NUM_ENTRIES never match any e, so such writes drop.
    assign sel = cfg_we && (slot == SLOT_W'(e));

    always_comb begin
      ctrl_en = sel && (wsel == WD_CTRL);
      lo_en   = sel && (wsel == WD_BASE_LO);
      hi_en   = sel && (wsel == WD_BASE_HI);
      attr_en = sel && (wsel == WD_ATTR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
      end else if (ctrl_en) begin
        valid_q <= cfg_wdata[0];
      end
    end

    always_ff @(posedge clk) begin
      if (lo_en) begin
        base_q[WORD_W-1:0] <= cfg_wdata;
      end
      if (hi_en) begin
        base_q[BASE_W-1:WORD_W] <= cfg_wdata[BASE_HI_W-1:0];
      end
      if (attr_en) begin
        attr_q <= cfg_wdata[ATTR_W-1:0];
      end
    end

    assign valid_o[e]     = valid_q;
    assign data_o[e].base = base_q;
    assign data_o[e].attr = attr_q;
  end

endmodule

// File: rtl/page_xlat_lookup.sv
module page_xlat_lookup
  import page_xlat_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned PAGE_SHIFT  = 14,
  parameter bit          OUTBOUND    = 1'b0
) (
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_ENTRIES-1:0]        valid_i,
  input  entry_data_t [NUM_ENTRIES-1:0] data_i,
  output logic                          err,
  output logic [ADDR_W-1:0]             xaddr,
  output logic [ATTR_W-1:0]             attr
);

  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);
  localparam logic [ADDR_W-1:0] PAGE_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  sel_idx;
  logic              in_range;
  logic              hit;
  entry_data_t       ent;
  logic [ADDR_W-1:0] base_ext;
  logic [ADDR_W-1:0] spliced;
  logic [ADDR_W-1:0] limited;

  always_comb begin
    idx      = addr[PAGE_SHIFT +: IDX_W];
    in_range = ({1'b0, idx} < (IDX_W+1)'(NUM_ENTRIES));
    sel_idx  = in_range ? idx : '0;
    ent      = data_i[sel_idx];
    hit      = in_range && valid_i[sel_idx];
    base_ext = {ent.base, {GRAN_SHIFT{1'b0}}};
    spliced  = (base_ext & ~PAGE_MASK) | (addr & PAGE_MASK);
  end

  if (OUTBOUND) begin : g_limit
    assign limited = {{(ADDR_W-LIMIT_W){1'b0}}, spliced[LIMIT_W-1:0]};
  end else begin : g_full
    assign limited = spliced;
  end

  always_comb begin
    err   = !hit;
    xaddr = hit ? limited  : '0;
    attr  = hit ? ent.attr : '0;
  end

endmodule

// File: rtl/page_xlat_result.sv
module page_xlat_result
  import page_xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              err_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [ATTR_W-1:0] attr_d,
  output logic              res_valid,
  output logic              res_err,
  output logic [ADDR_W-1:0] res_addr,
  output logic [ATTR_W-1:0] res_attr
);

  logic              valid_q, valid_d;
  logic              data_en;
  logic              err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ATTR_W-1:0] attr_q;

  always_comb begin
    valid_d = lk_valid;
    data_en = lk_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      err_q  <= err_d;
      addr_q <= addr_d;
      attr_q <= attr_d;
    end
  end

  assign res_valid = valid_q;
  assign res_err   = err_q;
  assign res_addr  = addr_q;
  assign res_attr  = attr_q;

endmodule

// File: rtl/page_xlat_table.sv
module page_xlat_table
  import page_xlat_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned PAGE_SHIFT  = 14,
  parameter bit          OUTBOUND    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [11:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        lk_valid,
  input  logic [63:0] lk_addr,
  output logic        res_valid,
  output logic        res_err,
  output logic [63:0] res_addr,
  output logic [15:0] res_attr
);

  logic                          rst_q_n;
  logic [NUM_ENTRIES-1:0]        ent_valid;
  entry_data_t [NUM_ENTRIES-1:0] ent_data;
  logic                          lk_err;
  logic [ADDR_W-1:0]             lk_xaddr;
  logic [ATTR_W-1:0]             lk_attr;

  page_xlat_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  page_xlat_store #(
    .NUM_ENTRIES (NUM_ENTRIES)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .valid_o   (ent_valid),
    .data_o    (ent_data)
  );

  page_xlat_lookup #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .OUTBOUND    (OUTBOUND)
  ) u_lookup (
    .addr    (lk_addr),
    .valid_i (ent_valid),
    .data_i  (ent_data),
    .err     (lk_err),
    .xaddr   (lk_xaddr),
    .attr    (lk_attr)
  );

  page_xlat_result u_result (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .lk_valid  (lk_valid),
    .err_d     (lk_err),
    .addr_d    (lk_xaddr),
    .attr_d    (lk_attr),
    .res_valid (res_valid),
    .res_err   (res_err),
    .res_addr  (res_addr),
    .res_attr  (res_attr)
  );

endmodule

// File: rtl/page_xlat_checker.sv
module page_xlat_checker #(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned PAGE_SHIFT  = 14,
  parameter bit          OUTBOUND    = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [11:0] cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        lk_valid,
  input logic [63:0] lk_addr,
  input logic        res_valid,
  input logic        res_err,
  input logic [63:0] res_addr,
  input logic [15:0] res_attr
);

  localparam int unsigned IDX_W = $clog2(NUM_ENTRIES);

  logic [7:0] lk_slot;
  logic       clear_wr;
  assign lk_slot  = 8'(lk_addr[PAGE_SHIFT +: IDX_W]);
  assign clear_wr = cfg_we && (cfg_addr[3:2] == 2'd0) && !cfg_wdata[0];

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);

  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_err) |->
      (res_addr[PAGE_SHIFT-1:0] == $past(lk_addr[PAGE_SHIFT-1:0])));

  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_addr == 64'd0 && res_attr == 16'd0));

  p_cleared_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(clear_wr) && (lk_slot == $past(cfg_addr[11:4])))
      |=> res_err);

  if (OUTBOUND) begin : g_limit_chk
    p_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_addr[63:52] == 12'd0));
  end

endmodule

bind page_xlat_table page_xlat_checker #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .PAGE_SHIFT  (PAGE_SHIFT),
  .OUTBOUND    (OUTBOUND)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .lk_valid  (lk_valid),
  .lk_addr   (lk_addr),
  .res_valid (res_valid),
  .res_err   (res_err),
  .res_addr  (res_addr),
  .res_attr  (res_attr)
);

// File: tb/page_xlat_table_test.sv
`timescale 1ns/1ps
module page_xlat_table_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        lk_valid = 1'b0;
  logic [63:0] lk_addr = '0;

  logic        a_valid, a_err, b_valid, b_err;
  logic [63:0] a_addr, b_addr;
  logic [15:0] a_attr, b_attr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // Instance 0: 64 entries, 16 KB pages, full width.
  page_xlat_table #(.NUM_ENTRIES(64), .PAGE_SHIFT(14), .OUTBOUND(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(a_valid), .res_err(a_err), .res_addr(a_addr), .res_attr(a_attr));

  // Instance 1: 12 entries (4-bit index, so 12..15 are out of range), 64 KB pages, 52-bit limit.
  page_xlat_table #(.NUM_ENTRIES(12), .PAGE_SHIFT(16), .OUTBOUND(1'b1)) uut_ob (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .res_valid(b_valid), .res_err(b_err), .res_addr(b_addr), .res_attr(b_attr));

  int          n_i  [2] = '{64, 12};
  int          ps_i [2] = '{14, 16};
  int          im_i [2] = '{63, 15};
  bit          ob_i [2] = '{1'b0, 1'b1};
  logic        m_v  [2][256];
  logic [51:0] m_b  [2][256];
  logic [15:0] m_a  [2][256];

  task automatic chk(input string req, input string inst, input logic [81:0] act, input logic [81:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, inst, act, exp);
    end
  endtask

  task automatic model_write(input logic [11:0] wa, input logic [31:0] wd);
    for (int i = 0; i < 2; i++) begin
      int s;
      s = int'(wa[11:4]);
      if (s < n_i[i]) begin
        case (wa[3:2])
          2'd0: m_v[i][s] = wd[0];
          2'd1: m_b[i][s][31:0] = wd;
          2'd2: m_b[i][s][51:32] = wd[19:0];
          default: m_a[i][s] = wd[15:0];
        endcase
      end
    end
  endtask

  task automatic model_lookup(input int i, input logic [63:0] la, output logic e,
                              output logic [63:0] x, output logic [15:0] t);
    int idx;
    logic [63:0] pm;
    idx = int'((la >> ps_i[i]) & 64'(im_i[i]));
    if (idx >= n_i[i] || !m_v[i][idx]) begin
      e = 1'b1; x = '0; t = '0;
    end else begin
      pm = (64'd1 << ps_i[i]) - 64'd1;
      x  = ({m_b[i][idx], 12'h000} & ~pm) | (la & pm);
      if (ob_i[i]) x = x & ((64'd1 << 52) - 64'd1);
      e = 1'b0; t = m_a[i][idx];
    end
  endtask

  task automatic cyc(input bit wr, input logic [11:0] wa, input logic [31:0] wd,
                     input bit lk, input logic [63:0] la, input string tag);
    logic e0, e1;
    logic [63:0] x0, x1;
    logic [15:0] t0, t1;
    model_lookup(0, la, e0, x0, t0);
    model_lookup(1, la, e1, x1, t1);
    cfg_we = wr; cfg_addr = wa; cfg_wdata = wd; lk_valid = lk; lk_addr = la;
    @(negedge clk);
    if (wr) model_write(wa, wd);
    if (lk) begin
      chk(tag, "uut",    {a_valid, a_err, a_addr, a_attr}, {1'b1, e0, x0, t0});
      chk(tag, "uut_ob", {b_valid, b_err, b_addr, b_attr}, {1'b1, e1, x1, t1});
    end else begin
      chk("R6", "both", 82'({a_valid, b_valid}), 82'd0);
    end
    cfg_we = 1'b0; lk_valid = 1'b0;
  endtask

  task automatic wr_entry(input int s, input logic [51:0] base, input logic [15:0] at, input bit v);
    cyc(1, 12'(s * 16 + 4),  base[31:0], 0, '0, "R5");
    cyc(1, 12'(s * 16 + 8),  32'(base[51:32]), 0, '0, "R5");
    cyc(1, 12'(s * 16 + 12), {16'hDEAD, at}, 0, '0, "R5");
    cyc(1, 12'(s * 16),      {31'h0, v}, 0, '0, "R5");
  endtask

  initial begin
    void'($urandom(32'd7341));
    for (int i = 0; i < 2; i++)
      for (int s = 0; s < 256; s++) begin
        m_v[i][s] = 1'b0; m_b[i][s] = '0; m_a[i][s] = '0;
      end
    repeat (3) @(negedge clk);
    chk("R8", "both", 82'({a_valid, b_valid}), 82'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: all entries invalid after reset
    cyc(0, '0, '0, 1, 64'h0000_0000_0000_0123, "R8");
    cyc(0, '0, '0, 1, 64'h0000_0000_00FC_4000, "R8");
    cyc(0, '0, '0, 1, 64'h0000_0000_0005_0000, "R8");

    // R5/R3/R4: entry 1 with low base bits set to test the page mask
    wr_entry(1, 52'hF_1234_5678_9FFF, 16'hA5C3, 1'b1);
    cyc(0, '0, '0, 1, 64'h0000_0000_0000_7ABC, "R3");
    cyc(0, '0, '0, 1, 64'h0000_0000_0001_3FFF, "R4");
    // R1: bits above the index do not affect selection
    cyc(0, '0, '0, 1, 64'hABC0_0000_0000_4001, "R1");
    cyc(0, '0, '0, 1, 64'hFFFF_FFF0_0001_0010, "R1");

    // R9: high base bits are cut at 52 in the outbound instance
    wr_entry(2, 52'hF_FFFF_0000_0000, 16'h0011, 1'b1);
    cyc(0, '0, '0, 1, 64'h0000_0000_0002_8000, "R9");
    cyc(0, '0, '0, 1, 64'h0000_0000_0000_8000, "R9");

    // R5: single-word write leaves the other fields
    cyc(1, 12'h01C, 32'h0000_7E7E, 0, '0, "R5");
    cyc(0, '0, '0, 1, 64'h0000_0000_0001_0004, "R5");

    // R11: slots past the end do not touch entries (slot 64 and 12)
    wr_entry(0, 52'h0_0000_0ABC_D000, 16'h1111, 1'b1);
    cyc(1, 12'h404, 32'hFFFF_FFFF, 0, '0, "R11");
    cyc(1, 12'h40C, 32'h0000_2222, 0, '0, "R11");
    cyc(1, 12'h0C4, 32'h5555_5555, 0, '0, "R11");
    cyc(1, 12'h0C0, 32'h1, 0, '0, "R11");
    cyc(0, '0, '0, 1, 64'h0000_0000_0000_1234, "R11");
    // R2: out-of-range index 12 and 13 in the 12-entry instance
    cyc(0, '0, '0, 1, 64'h0000_0000_000C_0000, "R2");
    cyc(0, '0, '0, 1, 64'h0000_0000_000D_1111, "R2");

    // R7: clear entry 1 and look it up in the same cycle; old contents come back
    cyc(1, 12'h010, 32'h0, 1, 64'h0000_0000_0000_4567, "R7");
    cyc(0, '0, '0, 1, 64'h0000_0000_0000_4567, "R2");
    // R10: error outputs are zero after earlier hits
    cyc(0, '0, '0, 1, 64'h0000_0000_0000_0000, "R10");
    cyc(0, '0, '0, 1, 64'h0000_0000_0030_0000, "R10");

    // Fill every slot with random contents, mostly valid
    for (int s = 0; s < 64; s++)
      wr_entry(s, {$urandom, $urandom}, 16'($urandom), ($urandom_range(0, 3) != 0));

    // Random mix of writes and lookups, back to back
    for (int k = 0; k < 800; k++) begin
      bit          w, l;
      logic [11:0] wa;
      logic [31:0] wd;
      w  = ($urandom_range(0, 3) == 0);
      l  = ($urandom_range(0, 4) != 0);
      wa = {8'($urandom_range(0, 79)), 2'($urandom_range(0, 3)), 2'b00};
      wd = $urandom;
      if (wa[3:2] == 2'd0) wd[0] = ($urandom_range(0, 3) != 0);
      cyc(w, wa, wd, l, {$urandom, $urandom}, "R3");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule